// File: doc/BRIEF.md
# Compact Serial Port with Register File

This block is a small asynchronous serial port for a system bus. Software programs it through a word-addressed register file whose layout resembles the classic 16550 but is simpler. Each frame has one start bit, then 7 or 8 data bits sent least significant bit first, then one stop bit, with no parity. Transmit and receive each have an 8-entry FIFO.

A single oversampling tick sets the bit rate for both directions. It runs at the system clock divided by a 16-bit divisor, and one bit lasts 8 ticks. A separate enable register starts and stops each direction. The interrupt output covers two sources: receive data present and transmit FIFO empty. Two enable bits gate the interrupt output as a whole. The port also provides a software-driven RTS output and a readable CTS input.

The bus address is a byte address. Registers are 4 bytes apart, so bits [5:2] select the register. Reads return data on `bus_rdata` one clock after `bus_rd`.

Top module: `mini_serial_port`

## Requirements
- R1: Register index (bus_addr[5:2]): 0 data, 1 irq enable, 2 irq id, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 direction enable, 9 extra status, 10 divisor. Scratch keeps 8 bits, the divisor keeps 16 bits, and irq enable keeps bits [3:0]. Bits that are not implemented, and writes to status registers, are ignored, and such bits read as 0. Extra status bit 0 means receive data is present; bit 1 means the transmit FIFO has space.
- R2: A frame is start (low), data LSB first, stop (high). Each bit lasts 8 × divisor clocks. While nothing is being sent, txd is high.
- R3: Line control bit 0 = 0 selects 7 data bits and bit 0 = 1 selects 8 data bits. In 7-bit mode, received bytes read with bit 7 = 0.
- R4: The receiver samples 8 times per bit and takes each bit at mid-bit. A low pulse that has ended before the middle of the start bit produces no byte.
- R5: Each FIFO holds 8 entries in order. Line status bit 5 is 0 when the transmit FIFO holds 8 entries.
- R6: A byte that completes while the receive FIFO is full is dropped, and line status bit 1 is set. Reading line status clears bit 1.
- R7: Line status bit 0 means receive data is present. Bit 6 means the transmit FIFO is empty and the shifter is idle.
- R8: irq goes high only when irq enable bits 3 and 2 are both 1 and an enabled source is active. Bit 0 enables the receive-data source and bit 1 enables the transmit-empty source.
- R9: The irq id register reads 0x01 when no source is active. It reads 0x04 for receive and 0x02 for transmit, never both at once, and receive wins.
- R10: Writing irq id with bit 1 set empties the transmit FIFO. Writing irq id with bit 2 set empties the receive FIFO.
- R11: Direction enable bit 0 runs the receiver and bit 1 runs the transmitter (reset value 0b11). A disabled side neither shifts nor takes bytes.
- R12: rts_out follows modem control bit 1. Modem status bit 5 reads cts_in.
- R13: Read data appears one clock after bus_rd. A data register read removes the head of the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address, register index in [5:2] |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Interrupt request, registered |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_out | output | 1 | Software-driven request-to-send |
| cts_in | input | 1 | Clear-to-send input |

## Verification
Register reads return data on the clock after the strobe, so the bench drives strobes at a falling edge and samples one full cycle later. irq follows a change to the enable register or the FIFO state by one clock, so the bench checks it two falling edges after the write. Received bytes pass through a two-flop synchronizer and are pushed at the middle of the stop bit, so the bench reads status only after the stop bit it drove has ended. Transmitted frames are decoded by waiting for the falling start edge and sampling every 8 × divisor clocks from the middle of the start bit. This decoding depends only on the bit time and not on when the transmitter pops the FIFO.

// File: rtl/mserial_pkg.sv
package mserial_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] RG_DATA  = 4'h0;
  localparam logic [IDX_W-1:0] RG_IEN   = 4'h1;
  localparam logic [IDX_W-1:0] RG_IID   = 4'h2;
  localparam logic [IDX_W-1:0] RG_LCTL  = 4'h3;
  localparam logic [IDX_W-1:0] RG_MCTL  = 4'h4;
  localparam logic [IDX_W-1:0] RG_LSTAT = 4'h5;
  localparam logic [IDX_W-1:0] RG_MSTAT = 4'h6;
  localparam logic [IDX_W-1:0] RG_SCR   = 4'h7;
  localparam logic [IDX_W-1:0] RG_XCTL  = 4'h8;
  localparam logic [IDX_W-1:0] RG_XSTAT = 4'h9;
  localparam logic [IDX_W-1:0] RG_BAUD  = 4'hA;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} frame_ph_e;
endpackage

// File: rtl/ms_fifo.sv
module ms_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ms_tx.sv
module ms_tx
  import mserial_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          wl8,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  output logic          txd,
  output logic          busy
);
  localparam int SW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(DW+1);
  localparam logic [SW-1:0] LAST = SW'(OSR-1);

  frame_ph_e     ph;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn, nbits;
  logic [DW-1:0] sh;

  assign nbits    = wl8 ? BW'(DW) : BW'(DW-1);
  assign fifo_pop = en && tick && (ph == PH_IDLE) && !fifo_empty;
  assign busy     = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      txd  <= 1'b1;
      sub  <= '0;
      bitn <= '0;
      sh   <= '0;
    end else if (en && tick) begin
      case (ph)
        PH_IDLE: if (!fifo_empty) begin
          ph  <= PH_START;
          txd <= 1'b0;
          sh  <= fifo_data;
          sub <= '0;
        end
        PH_START: if (sub == LAST) begin
          ph   <= PH_DATA;
          txd  <= sh[0];
          sh   <= sh >> 1;
          bitn <= '0;
          sub  <= '0;
        end else sub <= sub + 1'b1;
        PH_DATA: if (sub == LAST) begin
          sub <= '0;
          if (bitn == nbits - 1'b1) begin
            ph  <= PH_STOP;
            txd <= 1'b1;
          end else begin
            txd  <= sh[0];
            sh   <= sh >> 1;
            bitn <= bitn + 1'b1;
          end
        end else sub <= sub + 1'b1;
        default: if (sub == LAST) begin
          ph  <= PH_IDLE;
          sub <= '0;
        end else sub <= sub + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ms_rx.sv
module ms_rx
  import mserial_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          wl8,
  input  logic          rxd,
  output logic          push,
  output logic [DW-1:0] pdata
);
  localparam int SW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(DW+1);
  localparam logic [SW-1:0] LAST = SW'(OSR-1);
  localparam logic [SW-1:0] MID  = SW'(OSR/2 - 1);

  frame_ph_e     ph;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn, nbits;
  logic [DW-1:0] sh;

  assign nbits = wl8 ? BW'(DW) : BW'(DW-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      sub   <= '0;
      bitn  <= '0;
      sh    <= '0;
      push  <= 1'b0;
      pdata <= '0;
    end else begin
      push <= 1'b0;
      if (en && tick) begin
        case (ph)
          PH_IDLE: if (!rxd) begin
            ph  <= PH_START;
            sub <= '0;
          end
          PH_START: if (sub == MID) begin
            sub  <= '0;
            bitn <= '0;
            ph   <= rxd ? PH_IDLE : PH_DATA;
          end else sub <= sub + 1'b1;
          PH_DATA: if (sub == LAST) begin
            sub <= '0;
            sh  <= {rxd, sh[DW-1:1]};
            if (bitn == nbits - 1'b1) ph <= PH_STOP;
            else bitn <= bitn + 1'b1;
          end else sub <= sub + 1'b1;
          default: if (sub == LAST) begin
            sub   <= '0;
            ph    <= PH_IDLE;
            push  <= 1'b1;
            pdata <= wl8 ? sh : {1'b0, sh[DW-1:1]};
          end else sub <= sub + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/mini_serial_port.sv
module mini_serial_port
  import mserial_pkg::*;
#(
  parameter int          DEPTH     = 8,
  parameter int          DW        = 8,
  parameter int          OSR       = 8,
  parameter int          DIV_W     = 16,
  parameter logic [15:0] BAUD_INIT = 16'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        txd,
  input  logic        rxd,
  output logic        rts_out,
  input  logic        cts_in
);
  localparam int CW = $clog2(DEPTH+1);

  logic [IDX_W-1:0] idx;
  logic [1:0]       addr_lsb_unused;
  assign idx             = bus_addr[5:2];
  assign addr_lsb_unused = bus_addr[1:0];

  // Control and status state
  logic [3:0]       ier_q;
  logic [1:0]       lcr_q;
  logic [7:0]       scr_q;
  logic [1:0]       xctl_q;
  logic [DIV_W-1:0] div_q;
  logic             ovr_q;
  logic [1:0]       rxd_sync, cts_sync;

  // Oversampling tick
  logic [DIV_W-1:0] bcnt;
  logic             tick;
  assign tick = ({1'b0, bcnt} + 1'b1) >= {1'b0, div_q};

  always_ff @(posedge clk) begin
    if (rst || tick) bcnt <= '0;
    else             bcnt <= bcnt + 1'b1;
  end

  // FIFOs and engines
  logic          tx_push, tx_pop, tx_clr, tx_empty, tx_full, tx_busy;
  logic [DW-1:0] tx_head;
  logic [CW-1:0] tx_cnt_unused;
  logic          rx_push, rx_pop, rx_clr, rx_empty, rx_full, ovf_evt;
  logic [DW-1:0] rx_head, rx_byte;
  logic [CW-1:0] rx_count;
  logic          tx_en, rx_en, wl8;

  assign tx_en   = xctl_q[1];
  assign rx_en   = xctl_q[0];
  assign wl8     = lcr_q[0];
  assign tx_push = bus_wr && (idx == RG_DATA);
  assign tx_clr  = bus_wr && (idx == RG_IID) && bus_wdata[1];
  assign rx_clr  = bus_wr && (idx == RG_IID) && bus_wdata[2];
  assign rx_pop  = bus_rd && (idx == RG_DATA);
  assign ovf_evt = rx_push && rx_full && !rx_clr;

  ms_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
    .wdata(bus_wdata[DW-1:0]), .rdata(tx_head), .empty(tx_empty),
    .full(tx_full), .count(tx_cnt_unused));

  ms_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
    .wdata(rx_byte), .rdata(rx_head), .empty(rx_empty),
    .full(rx_full), .count(rx_count));

  ms_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en), .tick(tick), .wl8(wl8),
    .fifo_empty(tx_empty), .fifo_data(tx_head), .fifo_pop(tx_pop),
    .txd(txd), .busy(tx_busy));

  ms_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .wl8(wl8),
    .rxd(rxd_sync[1]), .push(rx_push), .pdata(rx_byte));

  // Interrupt sources: receive has priority
  logic src_rx, src_tx, pend;
  assign src_rx = ier_q[0] && !rx_empty;
  assign src_tx = ier_q[1] && tx_empty && !src_rx;
  assign pend   = src_rx || src_tx;

  // Register writes and misc state
  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q    <= '0;
      lcr_q    <= 2'b11;
      rts_out  <= 1'b0;
      scr_q    <= '0;
      xctl_q   <= 2'b11;
      div_q    <= DIV_W'(BAUD_INIT);
      ovr_q    <= 1'b0;
      irq      <= 1'b0;
      rxd_sync <= 2'b11;
      cts_sync <= 2'b00;
    end else begin
      rxd_sync <= {rxd_sync[0], rxd};
      cts_sync <= {cts_sync[0], cts_in};
      irq      <= (ier_q[3:2] == 2'b11) && pend;
      if (ovf_evt) ovr_q <= 1'b1;
      else if (bus_rd && idx == RG_LSTAT) ovr_q <= 1'b0;
      if (bus_wr) begin
        case (idx)
          RG_IEN:  ier_q   <= bus_wdata[3:0];
          RG_LCTL: lcr_q   <= bus_wdata[1:0];
          RG_MCTL: rts_out <= bus_wdata[1];
          RG_SCR:  scr_q   <= bus_wdata[7:0];
          RG_XCTL: xctl_q  <= bus_wdata[1:0];
          RG_BAUD: div_q   <= bus_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // Read path
  logic [15:0] rd_mux;
  logic        tx_space, tx_idle;
  assign tx_space = !tx_full;
  assign tx_idle  = tx_empty && !tx_busy;

  always_comb begin
    rd_mux = '0;
    case (idx)
      RG_DATA:  rd_mux[DW-1:0] = rx_empty ? '0 : rx_head;
      RG_IEN:   rd_mux[3:0]    = ier_q;
      RG_IID:   rd_mux[2:0]    = {src_rx, src_tx, !pend};
      RG_LCTL:  rd_mux[1:0]    = lcr_q;
      RG_MCTL:  rd_mux[1]      = rts_out;
      RG_LSTAT: begin
        rd_mux[0] = !rx_empty;
        rd_mux[1] = ovr_q;
        rd_mux[5] = tx_space;
        rd_mux[6] = tx_idle;
      end
      RG_MSTAT: rd_mux[5]      = cts_sync[1];
      RG_SCR:   rd_mux[7:0]    = scr_q;
      RG_XCTL:  rd_mux[1:0]    = xctl_q;
      RG_XSTAT: rd_mux[1:0]    = {tx_space, !rx_empty};
      RG_BAUD:  rd_mux[DIV_W-1:0] = div_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ms_serial_chk.sv
module ms_serial_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_rd,
  input logic [5:0]                 bus_addr,
  input logic [15:0]                bus_rdata,
  input logic                       irq,
  input logic                       txd,
  input logic [3:0]                 ier_q,
  input logic                       tx_en,
  input logic                       tx_busy,
  input logic                       rx_push,
  input logic                       rx_full,
  input logic                       rx_pop,
  input logic                       rx_clr,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       ovf_evt,
  input logic                       ovr_q
);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (ier_q[3:2] != 2'b11) |=> !irq);

  assert_iid_single_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[5:2] == 4'h2) |=>
      (!(bus_rdata[1] && bus_rdata[2]) && (bus_rdata[0] == !(bus_rdata[1] || bus_rdata[2]))));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !rx_pop && !rx_clr) |=> $stable(rx_count));

  assert_line_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  assert_tx_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && tx_busy) |=> $stable(txd));

  assert_ovr_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[5:2] == 4'h5 && !ovf_evt) |=> !ovr_q);
endmodule

bind mini_serial_port ms_serial_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .txd(txd), .ier_q(ier_q),
  .tx_en(tx_en), .tx_busy(tx_busy), .rx_push(rx_push), .rx_full(rx_full),
  .rx_pop(rx_pop), .rx_clr(rx_clr), .rx_count(rx_count),
  .ovf_evt(ovf_evt), .ovr_q(ovr_q));

// File: tb/mini_serial_port_bench.sv
`timescale 1ns/1ps
module mini_serial_port_bench;
  localparam int DIV = 2;
  localparam int BIT = 8 * DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, txd, rts_out;
  logic        rxd = 1'b1;
  logic        cts_in = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mini_serial_port u_mini_serial_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd), .rts_out(rts_out), .cts_in(cts_in));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [15:0] d);
    @(negedge clk);
    bus_addr = {idx, 2'b00}; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [15:0] d);
    @(negedge clk);
    bus_addr = {idx, 2'b00}; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_serial(input logic [7:0] b, input int nbits);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BIT + 4) @(negedge clk);
  endtask

  task automatic capture_tx(input int nbits, output logic [7:0] val, output logic stop_ok);
    val = '0;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (BIT/2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      repeat (BIT) @(negedge clk);
      val[i] = txd;
    end
    repeat (BIT) @(negedge clk);
    stop_ok = txd;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R2 txd idle after reset", {15'b0, txd}, 16'h1);
    check("R8 irq low after reset", {15'b0, irq}, 16'h0);
    check("R12 rts low after reset", {15'b0, rts_out}, 16'h0);
    rd(4'h5, d); check("R7 reset line status", d, 16'h0060);
    rd(4'h2, d); check("R9 reset irq id", d, 16'h0001);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(4'h1, 16'hFFFF); rd(4'h1, d); check("R1 irq enable keeps [3:0]", d, 16'h000F);
    wr(4'h1, 16'h0000);
    wr(4'h7, 16'hA55A); rd(4'h7, d); check("R1 scratch", d, 16'h005A);
    wr(4'hA, 16'h1234); rd(4'hA, d); check("R1 divisor 16 bit", d, 16'h1234);
    wr(4'hA, 16'(DIV));
    wr(4'h9, 16'hFFFF); rd(4'h9, d); check("R1 extra status ignores write", d, 16'h0002);
    wr(4'h4, 16'hFFFF); rd(4'h4, d); check("R1 modem control bit 1 only", d, 16'h0002);
    check("R12 rts follows modem control", {15'b0, rts_out}, 16'h1);
    wr(4'h4, 16'h0000);
    check("R12 rts cleared", {15'b0, rts_out}, 16'h0);
  endtask

  task automatic t_cts;
    logic [15:0] d;
    cts_in = 1'b1; repeat (4) @(negedge clk);
    rd(4'h6, d); check("R12 cts high in modem status", d, 16'h0020);
    cts_in = 1'b0; repeat (4) @(negedge clk);
    rd(4'h6, d); check("R12 cts low in modem status", d, 16'h0000);
  endtask

  task automatic t_tx8;
    logic [7:0] v; logic s; logic [15:0] d;
    wr(4'h0, 16'h00A5);
    capture_tx(8, v, s);
    check("R2 8-bit frame data", {8'h0, v}, 16'h00A5);
    check("R2 stop bit high", {15'b0, s}, 16'h1);
    rd(4'h5, d); check("R7 idle after send", d, 16'h0060);
  endtask

  task automatic t_rx8;
    logic [15:0] d;
    send_serial(8'h3C, 8);
    rd(4'h5, d); check("R7 receive data present", d, 16'h0061);
    rd(4'h0, d); check("R13 received byte", d, 16'h003C);
    rd(4'h5, d); check("R13 read removed byte", d, 16'h0060);
  endtask

  task automatic t_7bit;
    logic [7:0] v; logic s; logic [15:0] d;
    wr(4'h3, 16'h0000);
    wr(4'h0, 16'h00C3);
    capture_tx(7, v, s);
    check("R3 7-bit frame data", {8'h0, v}, 16'h0043);
    check("R3 stop follows bit 6", {15'b0, s}, 16'h1);
    send_serial(8'h7F, 7);
    rd(4'h0, d); check("R3 7-bit receive bit7 zero", d, 16'h007F);
    wr(4'h3, 16'h0003);
  endtask

  task automatic t_glitch;
    logic [15:0] d;
    @(negedge clk); rxd = 1'b0;
    repeat (2) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(4'h5, d); check("R4 short low pulse rejected", d, 16'h0060);
  endtask

  task automatic t_overrun;
    logic [15:0] d;
    for (int i = 0; i < 9; i++) send_serial(8'(8'h10 + i), 8);
    rd(4'h5, d); check("R6 overrun flag set", d, 16'h0063);
    rd(4'h5, d); check("R6 overrun cleared by read", d, 16'h0061);
    for (int i = 0; i < 8; i++) begin
      rd(4'h0, d); check("R5 receive order", d, 16'(8'h10 + i));
    end
    rd(4'h5, d); check("R6 ninth byte dropped", d, 16'h0060);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    send_serial(8'h81, 8);
    wr(4'h1, 16'h0001); repeat (2) @(negedge clk);
    check("R8 irq blocked without bits 3:2", {15'b0, irq}, 16'h0);
    wr(4'h1, 16'h000D); repeat (2) @(negedge clk);
    check("R8 receive irq", {15'b0, irq}, 16'h1);
    rd(4'h2, d); check("R9 receive id", d, 16'h0004);
    wr(4'h1, 16'h000F);
    rd(4'h2, d); check("R9 receive wins over transmit", d, 16'h0004);
    rd(4'h0, d); check("R13 irq byte", d, 16'h0081);
    rd(4'h2, d); check("R9 transmit id", d, 16'h0002);
    check("R8 transmit irq", {15'b0, irq}, 16'h1);
    wr(4'h1, 16'h000C); repeat (2) @(negedge clk);
    rd(4'h2, d); check("R9 none pending", d, 16'h0001);
    check("R8 irq low with no source", {15'b0, irq}, 16'h0);
    wr(4'h1, 16'h0000);
  endtask

  task automatic t_clear;
    logic [15:0] d;
    send_serial(8'h11, 8); send_serial(8'h22, 8);
    wr(4'h2, 16'h0004);
    rd(4'h5, d); check("R10 receive FIFO cleared", d, 16'h0060);
    wr(4'h8, 16'h0001);
    for (int i = 0; i < 3; i++) wr(4'h0, 16'(i));
    rd(4'h5, d); check("R7 not idle with queued bytes", d, 16'h0020);
    for (int i = 0; i < 5; i++) wr(4'h0, 16'(i));
    rd(4'h5, d); check("R5 transmit FIFO full", d, 16'h0000);
    wr(4'h2, 16'h0002);
    rd(4'h5, d); check("R10 transmit FIFO cleared", d, 16'h0060);
    wr(4'h8, 16'h0003);
  endtask

  task automatic t_disable;
    logic [7:0] v; logic s; logic [15:0] d; int lows;
    wr(4'h8, 16'h0001);
    wr(4'h0, 16'h005A);
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    check("R11 disabled transmitter silent", 16'(lows), 16'h0);
    wr(4'h8, 16'h0003);
    capture_tx(8, v, s);
    check("R11 transmitter resumes", {8'h0, v}, 16'h005A);
    wr(4'h8, 16'h0002);
    send_serial(8'h66, 8);
    rd(4'h5, d); check("R11 disabled receiver takes nothing", d, 16'h0060);
    wr(4'h8, 16'h0003);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, all requirements incomplete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_cts();
    t_tx8();
    t_rx8();
    t_7bit();
    t_glitch();
    t_overrun();
    t_irq();
    t_clear();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule